// File: doc/BRIEF.md
# BCD Real-Time Calendar Register Bank

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, day of month, day of week, month and a two-digit year as BCD bytes, and advances them by one second whenever the one-second `tick` input is high for a clock cycle. The carry ripples from seconds up to the year. Day-of-month rollover follows a per-month length table with a leap February. The hour byte runs either as a 24-hour BCD count or as a 12-hour count with a PM flag, chosen by a control bit.

Software reaches the bank through a byte-wide register port. `acc_start` loads an internal address pointer. Each write strobe stores `wdata` at the pointer and moves the pointer on by one. Each read acknowledge moves the pointer on after the byte shown on `rdata` has been taken. Bursts therefore walk through the control bytes and time bytes in address order. A sticky flag in bit 7 of the seconds byte reports that the time cannot be trusted. It is raised by reset, by a software reset and by stopping the clock, and software lowers it when it rewrites the seconds.

Register map: 0x0 control A, 0x1 control B, 0x2 control C, 0x3 seconds, 0x4 minutes, 0x5 hours, 0x6 day of month, 0x7 day of week, 0x8 month, 0x9 year. Control A bit 3 selects 12-hour mode, bit 4 requests a software reset, and bit 5 halts the clock. Control B and control C are plain storage bytes for a neighbouring alarm block.

Top module: `bcd_rtc_regs`

## Requirements
- R1: After reset the bytes at 0x0 to 0x9 read 00, 00, 00, 80, 00, 00, 01, 00, 01, 00. The seconds byte reads 0x80 because the integrity flag is set.
- R2: `acc_start` loads the pointer from `acc_addr`. Each `wr_en` or `rd_ack` then advances the pointer by one, and 0x9 wraps to 0x0. `rdata` always shows the byte at the pointer. Pointers 0xA to 0xF read 0x00, ignore writes, and advance to 0x0. Control B and control C store and return all 8 bits.
- R3: Seconds and minutes count in BCD from 00 to 59. A tick at 59 seconds gives 00 and carries into minutes. Minutes at 59 carry into hours.
- R4: In 24-hour mode (control A bit 3 = 0) the hours count in BCD from 00 to 23. 23 rolls to 00 and carries into the day.
- R5: In 12-hour mode (control A bit 3 = 1) hours bits 4:0 hold BCD 01 to 12 and bit 5 is PM. The sequence is 11AM to 12PM, 12 to 01 with PM unchanged, and 11PM to 12AM. Only the 11PM to 12AM step carries into the day.
- R6: The day of month rolls to 01 after 31, or 30 for months 04, 06, 09 and 11. In February it rolls after 28, or after 29 when the year value is divisible by 4. Month rolls 12 to 01 and carries into the year. The year rolls 99 to 00.
- R7: The day of week counts from 0 to 6. It advances every time the day of month advances, and 6 wraps to 0.
- R8: While control A bit 5 is set, ticks change no time byte. Writing control A with bit 5 set raises the integrity flag.
- R9: The integrity flag is seconds bit 7. A write to seconds with bit 7 = 0 clears it. A write to seconds with bit 7 = 1 leaves it unchanged.
- R10: Writing control A with bit 4 set restores every register to its R1 value, including the integrity flag. Control A bit 4 always reads 0.
- R11: Bits that have no meaning always read zero, whatever is written: minutes bit 7, hours bits 7:6, day of month bits 7:6, day of week bits 7:3 and month bits 7:5.
- R12: A write that lands in the same cycle as a tick takes priority in the written field. The tick's carry out of that field is dropped, so the fields above it keep their values. Fields below the written one still advance.
- R13: When `acc_start` and `wr_en` are high in the same cycle, the pointer is loaded and nothing is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second advance pulse, one clock wide |
| acc_start | input | 1 | Load the address pointer |
| acc_addr | input | AW | Address loaded on `acc_start` |
| wr_en | input | 1 | Write `wdata` at the pointer, then advance |
| wdata | input | 8 | Write data |
| rd_ack | input | 1 | Advance the pointer after a read |
| rdata | output | 8 | Byte at the current pointer |

## Verification
The bench builds the bank with the default 4-bit address, which covers the whole ten-byte map plus the six unused addresses. The bench walks the calendar day by day across four consecutive years starting at year 23. This reaches every month length, both leap and common Februaries, and every day-of-week wrap. It also steps a full minute of seconds, all 24 hours in 12-hour form, and the century rollover, with expected values computed arithmetically from the date.

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          acc_start,
  input  logic [AW-1:0] acc_addr,
  input  logic          wr_en,
  input  logic [7:0]    wdata,
  input  logic          rd_ack,
  output logic [7:0]    rdata
);
  localparam int NREG = 10;
  localparam logic [AW-1:0] A_LAST = AW'(NREG - 1);

  logic [AW-1:0] ptr;
  logic [7:0] ctrl1, ctrl2, ctrl3, yr;
  logic [6:0] sec, mnt;
  logic [5:0] hr, dt;
  logic [4:0] mo;
  logic [2:0] wd;
  logic       osf;

  logic wr;
  logic [NREG-1:0] wsel;
  assign wr = wr_en & ~acc_start;
  for (genvar k = 0; k < NREG; k++) begin : g_sel
    assign wsel[k] = wr && (ptr == AW'(k));
  end

  logic mode12, adv, soft_rst;
  assign mode12   = ctrl1[3];
  assign adv      = tick & ~ctrl1[5];
  assign soft_rst = wsel[0] & wdata[4];

  logic [6:0] sec_inc, mnt_inc;
  logic [5:0] hr_inc, dt_inc, h_next;
  logic [4:0] h12_inc, mo_inc;
  logic [7:0] yr_inc;
  assign sec_inc = (sec[3:0] == 4'd9) ? {sec[6:4] + 3'd1, 4'd0} : sec + 7'd1;
  assign mnt_inc = (mnt[3:0] == 4'd9) ? {mnt[6:4] + 3'd1, 4'd0} : mnt + 7'd1;
  assign hr_inc  = (hr[3:0]  == 4'd9) ? {hr[5:4]  + 2'd1, 4'd0} : hr + 6'd1;
  assign h12_inc = (hr[3:0]  == 4'd9) ? {hr[4] + 1'b1, 4'd0} : hr[4:0] + 5'd1;
  assign dt_inc  = (dt[3:0]  == 4'd9) ? {dt[5:4]  + 2'd1, 4'd0} : dt + 6'd1;
  assign mo_inc  = (mo[3:0]  == 4'd9) ? {mo[4] + 1'b1, 4'd0} : mo + 5'd1;
  assign yr_inc  = (yr[3:0]  == 4'd9) ? {yr[7:4]  + 4'd1, 4'd0} : yr + 8'd1;

  logic s_roll, m_roll, h_roll, d_roll, mo_roll;
  assign s_roll  = sec >= 7'h59;
  assign m_roll  = mnt >= 7'h59;
  assign mo_roll = mo >= 5'h12;

  always_comb begin
    h_roll = 1'b0;
    if (!mode12) begin
      h_roll = hr >= 6'h23;
      h_next = h_roll ? 6'h00 : hr_inc;
    end else if (hr[4:0] == 5'h11) begin
      h_next = {~hr[5], 5'h12};
      h_roll = hr[5];
    end else if (hr[4:0] >= 5'h12) begin
      h_next = {hr[5], 5'h01};
    end else begin
      h_next = {hr[5], h12_inc};
    end
  end

  logic [1:0] lsum;
  logic [5:0] dim;
  assign lsum = {yr[4], 1'b0} + yr[1:0];
  always_comb begin
    case (mo)
      5'h02:                      dim = (lsum == 2'b00) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: dim = 6'h30;
      default:                    dim = 6'h31;
    endcase
  end
  assign d_roll = dt >= dim;

  logic c_min, c_hr, c_day, c_mon, c_yr;
  assign c_min = adv   & s_roll  & ~wsel[3];
  assign c_hr  = c_min & m_roll  & ~wsel[4];
  assign c_day = c_hr  & h_roll  & ~wsel[5];
  assign c_mon = c_day & d_roll  & ~wsel[6];
  assign c_yr  = c_mon & mo_roll & ~wsel[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (acc_start) begin
      ptr <= acc_addr;
    end else if (wr_en || rd_ack) begin
      ptr <= (ptr >= A_LAST) ? '0 : ptr + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      ctrl1 <= 8'h00; ctrl2 <= 8'h00; ctrl3 <= 8'h00;
      sec <= 7'h00; osf <= 1'b1; mnt <= 7'h00; hr <= 6'h00;
      dt <= 6'h01; wd <= 3'd0; mo <= 5'h01; yr <= 8'h00;
    end else begin
      if (wsel[0]) begin
        ctrl1 <= wdata & 8'hEF;
        if (wdata[5]) osf <= 1'b1;
      end
      if (wsel[1]) ctrl2 <= wdata;
      if (wsel[2]) ctrl3 <= wdata;
      if (wsel[3]) begin
        sec <= wdata[6:0];
        osf <= osf & wdata[7];
      end else if (adv) sec <= s_roll ? 7'h00 : sec_inc;
      if (wsel[4]) mnt <= wdata[6:0];
      else if (c_min) mnt <= m_roll ? 7'h00 : mnt_inc;
      if (wsel[5]) hr <= wdata[5:0];
      else if (c_hr) hr <= h_next;
      if (wsel[6]) dt <= wdata[5:0];
      else if (c_day) dt <= d_roll ? 6'h01 : dt_inc;
      if (wsel[7]) wd <= wdata[2:0];
      else if (c_day && !wsel[6]) wd <= (wd >= 3'd6) ? 3'd0 : wd + 3'd1;
      if (wsel[8]) mo <= wdata[4:0];
      else if (c_mon) mo <= mo_roll ? 5'h01 : mo_inc;
      if (wsel[9]) yr <= wdata;
      else if (c_yr) yr <= (yr >= 8'h99) ? 8'h00 : yr_inc;
    end
  end

  always_comb begin
    case (ptr)
      AW'(0):  rdata = ctrl1;
      AW'(1):  rdata = ctrl2;
      AW'(2):  rdata = ctrl3;
      AW'(3):  rdata = {osf, sec};
      AW'(4):  rdata = {1'b0, mnt};
      AW'(5):  rdata = {2'b00, hr};
      AW'(6):  rdata = {2'b00, dt};
      AW'(7):  rdata = {5'b0, wd};
      AW'(8):  rdata = {3'b0, mo};
      AW'(9):  rdata = yr;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_regs_chk.sv
module bcd_rtc_regs_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          acc_start,
  input logic [AW-1:0] acc_addr,
  input logic          wr_en,
  input logic [7:0]    wdata,
  input logic [AW-1:0] ptr,
  input logic [7:0]    rdata,
  input logic [6:0]    sec,
  input logic [6:0]    mnt,
  input logic [5:0]    hr,
  input logic          osf,
  input logic          stop,
  input logic          mode12
);
  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && tick && !wr_en) |=> $stable(sec));

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop && !wr_en && sec == 7'h59) |=> (sec == 7'h00));

  assert_hour_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop && !mode12 && !wr_en && sec == 7'h59 && mnt == 7'h59 && hr == 6'h23)
    |=> (hr == 6'h00));

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_start && ptr == AW'(3) && !wdata[7]) |=> !osf);

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_start && ptr == AW'(0) && wdata[4]) |=> (osf && sec == 7'h00));

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_start && ptr < AW'(9)) |=> (ptr == $past(ptr) + AW'(1)));

  assert_ptr_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> (ptr == $past(acc_addr)));

  assert_fixed_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == AW'(4) || ptr == AW'(5)) |-> (rdata[7] == 1'b0));
endmodule

bind bcd_rtc_regs bcd_rtc_regs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .acc_start(acc_start),
  .acc_addr(acc_addr), .wr_en(wr_en), .wdata(wdata), .ptr(ptr),
  .rdata(rdata), .sec(sec), .mnt(mnt), .hr(hr), .osf(osf),
  .stop(ctrl1[5]), .mode12(ctrl1[3])
);

// File: tb/sim_bcd_rtc_regs.sv
module sim_bcd_rtc_regs;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, acc_start = 1'b0;
  logic [3:0] acc_addr = '0;
  logic wr_en = 1'b0, rd_ack = 1'b0;
  logic [7:0] wdata = '0, rdata;
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  bcd_rtc_regs #(.AW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .acc_start(acc_start),
    .acc_addr(acc_addr), .wr_en(wr_en), .wdata(wdata), .rd_ack(rd_ack),
    .rdata(rdata)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] h12(input int h24);
    int h = h24 % 12;
    return bcd(h == 0 ? 12 : h) | (h24 >= 12 ? 8'h20 : 8'h00);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_ptr(input int a);
    acc_start = 1'b1; acc_addr = 4'(a);
    @(negedge clk);
    acc_start = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    d = rdata; rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_time(input int s, input int mi, input logic [7:0] h, input int d,
                          input int w, input int mo, input int y);
    set_ptr(3);
    wr(bcd(s)); wr(bcd(mi)); wr(h); wr(bcd(d)); wr(bcd(w)); wr(bcd(mo)); wr(bcd(y));
  endtask

  task automatic chk_reset_map(input string tag);
    logic [7:0] v;
    logic [7:0] exp [10] = '{8'h00, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00};
    set_ptr(0);
    for (int i = 0; i < 10; i++) begin
      rd(v); chk(tag, v, exp[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values, R2 burst order and wrap
    chk_reset_map("R1 reset map");
    rd(v); chk("R2 wrap to 0x0", v, 8'h00);

    // R9 flag write semantics
    set_ptr(3); wr(8'h85); set_ptr(3); chk("R9 bit7=1 keeps flag", rdata, 8'h85);
    wr(8'h05); set_ptr(3); chk("R9 bit7=0 clears flag", rdata, 8'h05);

    // R2 out of range addresses and control storage
    set_ptr(1); wr(8'hA5); wr(8'h3C);
    set_ptr(12); chk("R2 unused reads zero", rdata, 8'h00);
    wr(8'hFF); chk("R2 unused advances to 0", rdata, 8'h00);
    set_ptr(1); rd(v); chk("R2 ctrlB stored", v, 8'hA5);
    rd(v); chk("R2 ctrlC stored", v, 8'h3C);

    // R11 fixed zero bits
    set_ptr(4); for (int i = 0; i < 5; i++) wr(8'hFF);
    set_ptr(4);
    rd(v); chk("R11 minutes mask", v, 8'h7F);
    rd(v); chk("R11 hours mask", v, 8'h3F);
    rd(v); chk("R11 date mask", v, 8'h3F);
    rd(v); chk("R11 weekday mask", v, 8'h07);
    rd(v); chk("R11 month mask", v, 8'h1F);

    // R8 stop
    set_ptr(0); wr(8'h20);
    set_ptr(3); chk("R8 stop raises flag", rdata, 8'h85);
    wr(8'h05);
    repeat (5) do_tick();
    set_ptr(3); chk("R8 ticks ignored while stopped", rdata, 8'h05);
    set_ptr(0); chk("R8 ctrlA readback", rdata, 8'h20);
    wr(8'h00); do_tick();
    set_ptr(3); chk("R8 runs after release", rdata, 8'h06);

    // R10 software reset
    set_ptr(1); wr(8'h55);
    set_ptr(0); wr(8'h18);
    chk_reset_map("R10 soft reset map");
    set_ptr(3); wr(8'h00);

    // R13 load wins over write
    acc_start = 1'b1; acc_addr = 4'd7; wr_en = 1'b1; wdata = 8'h03;
    @(negedge clk);
    acc_start = 1'b0; wr_en = 1'b0;
    chk("R13 load without write", rdata, 8'h00);

    // R12 write/tick collisions
    set_time(59, 59, 8'h10, 1, 0, 1, 0);
    set_ptr(4);
    tick = 1'b1; wr_en = 1'b1; wdata = 8'h30;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    set_ptr(3);
    rd(v); chk("R12 lower field advances", v, 8'h00);
    rd(v); chk("R12 written field wins", v, 8'h30);
    rd(v); chk("R12 carry above dropped", v, 8'h10);
    set_time(59, 59, 8'h10, 1, 0, 1, 0);
    set_ptr(3);
    tick = 1'b1; wr_en = 1'b1; wdata = 8'h20;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    set_ptr(3);
    rd(v); chk("R12 seconds write wins", v, 8'h20);
    rd(v); chk("R12 minutes untouched", v, 8'h59);

    // R3 full minute of seconds
    set_time(0, 0, 8'h00, 1, 0, 1, 0);
    set_ptr(3);
    for (int i = 1; i <= 60; i++) begin
      do_tick();
      chk("R3 seconds count", rdata, bcd(i % 60));
    end
    set_ptr(4); chk("R3 minute carry", rdata, 8'h01);
    set_time(59, 59, 8'h07, 1, 0, 1, 0);
    do_tick();
    set_ptr(4); rd(v); chk("R3 minutes wrap", v, 8'h00);
    rd(v); chk("R3 hour carry", v, 8'h08);

    // R5 12-hour sequence
    set_ptr(0); wr(8'h08);
    set_time(59, 59, 8'h12, 5, 0, 3, 21);
    for (int h = 0; h < 24; h++) begin
      set_ptr(3); wr(8'h59); wr(8'h59);
      do_tick();
      set_ptr(5);
      rd(v); chk("R5 12h hour step", v, h12((h + 1) % 24));
      chk("R5 day carry only at 12AM", rdata, (h == 23) ? 8'h06 : 8'h05);
    end
    set_ptr(0); wr(8'h00);

    // R4 R6 R7 four-year calendar walk
    begin
      int d = 1, m = 1, y = 23, w = 0;
      set_time(59, 59, 8'h23, 1, 0, 1, 23);
      for (int n = 0; n < 1461; n++) begin
        set_ptr(3); wr(8'h59); wr(8'h59); wr(8'h23);
        do_tick();
        d++; w = (w + 1) % 7;
        if (d > mdays(m, y)) begin
          d = 1; m++;
          if (m > 12) begin m = 1; y = (y + 1) % 100; end
        end
        set_ptr(5);
        rd(v); chk("R4 hour wraps 23 to 00", v, 8'h00);
        rd(v); chk("R6 day of month", v, bcd(d));
        rd(v); chk("R7 day of week", v, bcd(w));
        rd(v); chk("R6 month", v, bcd(m));
        rd(v); chk("R6 year", v, bcd(y));
      end
    end

    // R6 century wrap and leap year 00
    set_time(59, 59, 8'h23, 31, 2, 12, 99);
    do_tick();
    set_ptr(6);
    rd(v); chk("R6 century date", v, 8'h01);
    rd(v); chk("R7 century weekday", v, 8'h03);
    rd(v); chk("R6 century month", v, 8'h01);
    rd(v); chk("R6 year 99 to 00", v, 8'h00);
    set_time(59, 59, 8'h23, 28, 0, 2, 0);
    do_tick();
    set_ptr(6); chk("R6 year 00 leap Feb 29", rdata, 8'h29);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule